// File: doc/BRIEF.md
# Fixed-Point 3x3 Colour Matrix

This block applies a programmable 3x3 matrix to a stream of RGB pixels with 12-bit unsigned components. Each output component is a weighted sum of the three input components. The weights are signed Q3.12 coefficients, held as 15-bit two's-complement values. Products are summed at full precision, rounded to the nearest integer and clamped to the 12-bit range. Pixels carry a valid qualifier and have no backpressure. The default result latency is two cycles.

Coefficients arrive one at a time as 64-bit sign-magnitude fixed-point words with 32 fraction bits. A converter keeps the 15 magnitude bits that form a Q3.12 value and negates them when the sign is set. It then rejects any word whose converted top bit disagrees with the sign. Because the range check follows the negation, the most negative code (-4.0) is still accepted. Accepted values land in shadow registers. All nine shadow values move to the active set on the same edge. This happens at the first frame-start pulse after a commit strobe, so a pixel never sees a mixture of old and new weights.

Top module: `rgb_matrix_xform`

## Requirements
- R1: After reset the shadow and active sets both hold the identity matrix: 0x1000 (1.0) at indices 0, 4 and 8 and zero elsewhere. pix_out_valid and coef_err are low.
- R2: Coefficient index k = row*3 + col. Output row 0 is red, row 1 green and row 2 blue, and column 0/1/2 weights the red/green/blue input. Each output equals clamp(floor((sum of coef*component + 2048) / 4096), 0, 4095), using the active set sampled in the pixel's input cycle.
- R3: pix_out_valid rises exactly two cycles after pix_in_valid, once per input pixel, and the output components are held valid in that cycle.
- R4: The converted coefficient is coef_data[34:20]. It is two's-complement negated when coef_data[63] is 1. Bits 62:35 and 19:0 have no effect.
- R5: A word is rejected when coef_data[63] differs from bit 14 of the converted value. For example, sign 1 with magnitude 0x4000 is accepted as -4.0, while sign 1 with magnitude 0 is rejected, and so is sign 0 with magnitude 0x4000 or above.
- R6: A rejected write to a valid index raises coef_err for exactly the cycle after the write. The shadow value at that index is left unchanged.
- R7: A write with coef_idx of 9 or more changes no coefficient and never raises coef_err.
- R8: Shadow writes do not reach the datapath until they are committed. A commit copies all nine values on one edge.
- R9: coef_commit arms a copy, which happens at the next frame_start pulse; a commit in the same cycle as frame_start copies at once. Each frame_start consumes the arm, so a later frame_start with no new commit copies nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Coefficient index, row*3+col |
| coef_data | input | 64 | Sign-magnitude coefficient, 32 fraction bits |
| coef_commit | input | 1 | Arms the shadow-to-active copy |
| frame_start | input | 1 | Frame boundary pulse |
| coef_err | output | 1 | Rejected write, one cycle after it |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_r | input | 12 | Input red |
| pix_in_g | input | 12 | Input green |
| pix_in_b | input | 12 | Input blue |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_r | output | 12 | Output red |
| pix_out_g | output | 12 | Output green |
| pix_out_b | output | 12 | Output blue |

## Verification
The conversion is swept over every 15-bit magnitude with both signs, with the ignored high and low bits scrambled. This separates the reject rule applied after negation from one applied before it, and catches negative zero and the -4.0 edge. A strided subset of the accepted values is committed and pushed through a pixel against a fixed offset term, which shows that the exact converted value reaches the multiplier. A mixed-sign matrix with full-scale, zero and mid-range pixels exercises the rounding and both clamps, and the row/column placement. Further patterns cover writes without commit, commit without frame start, a frame start that consumes an earlier arm, out-of-range indices and a rejected write following an accepted one; together they tell the shadow, arm and active stages apart.

// File: rtl/rgbmx_pkg.sv
package rgbmx_pkg;
   localparam int unsigned RGBMX_NCH   = 3;
   localparam int unsigned RGBMX_NCOEF = RGBMX_NCH * RGBMX_NCH;
   localparam int unsigned RGBMX_IDX_W = $clog2(RGBMX_NCOEF);

   typedef enum logic {
      CMT_IDLE  = 1'b0,
      CMT_ARMED = 1'b1
   } commit_state_e;
endpackage

// File: rtl/rgbmx_coef_conv.sv
module rgbmx_coef_conv #(
   parameter int unsigned IN_W      = 64,
   parameter int unsigned IN_FRAC   = 32,
   parameter int unsigned COEF_W    = 15,
   parameter int unsigned COEF_FRAC = 12
) (
   input  logic [IN_W-1:0]   raw,
   output logic [COEF_W-1:0] coef,
   output logic              bad
);
   localparam int unsigned LSB = IN_FRAC - COEF_FRAC;
   localparam int unsigned MSB = LSB + COEF_W - 1;

   generate
      if (MSB >= IN_W - 1) begin : g_bad_fit
         $error("coefficient field overlaps the sign bit");
      end
      if (LSB == 0) begin : g_bad_lsb
         $error("input needs more fraction bits than the coefficient");
      end
   endgenerate

   logic              neg;
   logic [COEF_W-1:0] mag;
   logic              unused_bits;

   assign neg         = raw[IN_W-1];
   assign mag         = raw[MSB:LSB];
   assign unused_bits = ^{raw[IN_W-2:MSB+1], raw[LSB-1:0]};

   always_comb begin
      if (neg) coef = ~mag + {{(COEF_W-1){1'b0}}, 1'b1};
      else     coef = mag;
      bad = neg ^ coef[COEF_W-1];
   end
endmodule

// File: rtl/rgbmx_coef_bank.sv
module rgbmx_coef_bank
   import rgbmx_pkg::*;
#(
   parameter int unsigned NCH       = 3,
   parameter int unsigned COEF_W    = 15,
   parameter int unsigned COEF_FRAC = 12,
   parameter int unsigned IDX_W     = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [IDX_W-1:0]              idx,
   input  logic [COEF_W-1:0]             coef,
   input  logic                          bad,
   input  logic                          commit,
   input  logic                          frame_start,
   output logic [NCH*NCH*COEF_W-1:0]     act_flat,
   output logic                          err,
   output logic                          armed
);
   localparam int unsigned        NCOEF = NCH * NCH;
   localparam logic [COEF_W-1:0]  ONE   = COEF_W'(1) << COEF_FRAC;

   generate
      if ((1 << IDX_W) < NCOEF) begin : g_bad_idx
         $error("index too narrow for the coefficient count");
      end
   endgenerate

   commit_state_e st;
   logic          do_copy;
   logic          idx_ok;

   assign idx_ok  = ({1'b0, idx} < (IDX_W+1)'(NCOEF));
   assign do_copy = frame_start && (st == CMT_ARMED || commit);
   assign armed   = (st == CMT_ARMED);

   always_ff @(posedge clk) begin
      if (!rst_n)           st <= CMT_IDLE;
      else if (frame_start) st <= CMT_IDLE;
      else if (commit)      st <= CMT_ARMED;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err <= 1'b0;
      else        err <= wr && idx_ok && bad;
   end

   genvar i;
   generate
      for (i = 0; i < NCOEF; i++) begin : g_coef
         localparam logic [COEF_W-1:0] INIT = ((i / NCH) == (i % NCH)) ? ONE : '0;
         logic [COEF_W-1:0] shadow_q;
         logic [COEF_W-1:0] active_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               shadow_q <= INIT;
            else if (wr && !bad && idx == IDX_W'(i))
               shadow_q <= coef;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)       active_q <= INIT;
            else if (do_copy) active_q <= shadow_q;
         end

         assign act_flat[i*COEF_W +: COEF_W] = active_q;
      end
   endgenerate
endmodule

// File: rtl/rgbmx_lane.sv
module rgbmx_lane #(
   parameter int unsigned NCH       = 3,
   parameter int unsigned COMP_W    = 12,
   parameter int unsigned COEF_W    = 15,
   parameter int unsigned COEF_FRAC = 12,
   parameter int unsigned PIPE_MUL  = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH*COMP_W-1:0]   pix_flat,
   input  logic [NCH*COEF_W-1:0]   row_flat,
   output logic [COMP_W-1:0]       res
);
   localparam int unsigned PW    = COEF_W + COMP_W + 1;
   localparam int unsigned SUM_W = PW + $clog2(NCH) + 1;
   localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (COEF_FRAC - 1);
   localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << COMP_W) - 1);

   logic signed [PW-1:0] prod_q [NCH];

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_mul
         logic signed [PW-1:0] prod;
         assign prod = $signed(row_flat[c*COEF_W +: COEF_W]) *
                       $signed({1'b0, pix_flat[c*COMP_W +: COMP_W]});
         if (PIPE_MUL != 0) begin : g_reg
            always_ff @(posedge clk) begin
               if (!rst_n) prod_q[c] <= '0;
               else        prod_q[c] <= prod;
            end
         end else begin : g_comb
            assign prod_q[c] = prod;
         end
      end
   endgenerate

   logic signed [SUM_W-1:0] acc;
   logic signed [SUM_W-1:0] shf;
   logic [COMP_W-1:0]       res_d;

   always_comb begin
      acc = HALF;
      for (int k = 0; k < NCH; k++)
         acc = acc + {{(SUM_W-PW){prod_q[k][PW-1]}}, prod_q[k]};
      shf = acc >>> COEF_FRAC;
      if (shf < 0)         res_d = '0;
      else if (shf > MAXV) res_d = MAXV[COMP_W-1:0];
      else                 res_d = shf[COMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) res <= '0;
      else        res <= res_d;
   end
endmodule

// File: rtl/rgb_matrix_xform.sv
module rgb_matrix_xform
   import rgbmx_pkg::*;
#(
   parameter int unsigned COMP_W    = 12,
   parameter int unsigned COEF_W    = 15,
   parameter int unsigned COEF_FRAC = 12,
   parameter int unsigned IN_W      = 64,
   parameter int unsigned IN_FRAC   = 32,
   parameter int unsigned PIPE_MUL  = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   coef_wr,
   input  logic [RGBMX_IDX_W-1:0] coef_idx,
   input  logic [IN_W-1:0]        coef_data,
   input  logic                   coef_commit,
   input  logic                   frame_start,
   output logic                   coef_err,
   input  logic                   pix_in_valid,
   input  logic [COMP_W-1:0]      pix_in_r,
   input  logic [COMP_W-1:0]      pix_in_g,
   input  logic [COMP_W-1:0]      pix_in_b,
   output logic                   pix_out_valid,
   output logic [COMP_W-1:0]      pix_out_r,
   output logic [COMP_W-1:0]      pix_out_g,
   output logic [COMP_W-1:0]      pix_out_b
);
   localparam int unsigned NCH   = RGBMX_NCH;
   localparam int unsigned NCOEF = RGBMX_NCOEF;
   localparam int unsigned LAT   = 1 + PIPE_MUL;
   localparam int unsigned ACT_W = NCOEF * COEF_W;

   generate
      if (COEF_FRAC >= COEF_W) begin : g_bad_frac
         $error("coefficient needs integer bits");
      end
      if (PIPE_MUL > 1) begin : g_bad_pipe
         $error("PIPE_MUL must be 0 or 1");
      end
      if (IN_FRAC <= COEF_FRAC) begin : g_bad_in
         $error("input fraction must exceed coefficient fraction");
      end
   endgenerate

   logic [COEF_W-1:0] conv_coef;
   logic              conv_bad;
   logic [ACT_W-1:0]  act_flat;
   logic              armed;

   rgbmx_coef_conv #(
      .IN_W(IN_W), .IN_FRAC(IN_FRAC), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
   ) u_conv (
      .raw(coef_data), .coef(conv_coef), .bad(conv_bad)
   );

   rgbmx_coef_bank #(
      .NCH(NCH), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .IDX_W(RGBMX_IDX_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(coef_wr), .idx(coef_idx),
      .coef(conv_coef), .bad(conv_bad), .commit(coef_commit),
      .frame_start(frame_start), .act_flat(act_flat), .err(coef_err),
      .armed(armed)
   );

   logic [NCH*COMP_W-1:0] pix_flat;
   logic [COMP_W-1:0]     lane_res [NCH];

   assign pix_flat = {pix_in_b, pix_in_g, pix_in_r};

   genvar r;
   generate
      for (r = 0; r < NCH; r++) begin : g_row
         rgbmx_lane #(
            .NCH(NCH), .COMP_W(COMP_W), .COEF_W(COEF_W),
            .COEF_FRAC(COEF_FRAC), .PIPE_MUL(PIPE_MUL)
         ) u_lane (
            .clk(clk), .rst_n(rst_n), .pix_flat(pix_flat),
            .row_flat(act_flat[r*NCH*COEF_W +: NCH*COEF_W]),
            .res(lane_res[r])
         );
      end
   endgenerate

   assign pix_out_r = lane_res[0];
   assign pix_out_g = lane_res[1];
   assign pix_out_b = lane_res[2];

   logic [LAT-1:0] vpipe;
   generate
      if (LAT == 1) begin : g_v1
         always_ff @(posedge clk) begin
            if (!rst_n) vpipe <= '0;
            else        vpipe <= pix_in_valid;
         end
      end else begin : g_vn
         always_ff @(posedge clk) begin
            if (!rst_n) vpipe <= '0;
            else        vpipe <= {vpipe[LAT-2:0], pix_in_valid};
         end
      end
   endgenerate

   assign pix_out_valid = vpipe[LAT-1];
endmodule

// File: rtl/rgbmx_chk.sv
module rgbmx_chk #(
   parameter int unsigned LAT   = 2,
   parameter int unsigned ACT_W = 135
) (
   input logic             clk,
   input logic             rst_n,
   input logic             coef_wr,
   input logic             coef_err,
   input logic             frame_start,
   input logic             armed,
   input logic [ACT_W-1:0] act_flat,
   input logic             in_valid,
   input logic             out_valid
);
   generate
      if (LAT == 2) begin : g_l2
         // R3
         valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(in_valid, 2));
      end else begin : g_l1
         // R3
         valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(in_valid));
      end
   endgenerate

   // R6
   err_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coef_err |-> $past(coef_wr));

   // R8
   active_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start) |-> $stable(act_flat));

   // R9
   arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !armed);
endmodule

bind rgb_matrix_xform rgbmx_chk #(.LAT(LAT), .ACT_W(ACT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .coef_wr(coef_wr), .coef_err(coef_err),
   .frame_start(frame_start), .armed(armed), .act_flat(act_flat),
   .in_valid(pix_in_valid), .out_valid(pix_out_valid)
);

// File: tb/sim_rgb_matrix_xform.sv
module sim_rgb_matrix_xform;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        coef_wr = 1'b0;
   logic [3:0]  coef_idx = '0;
   logic [63:0] coef_data = '0;
   logic        coef_commit = 1'b0;
   logic        frame_start = 1'b0;
   logic        coef_err;
   logic        pix_in_valid = 1'b0;
   logic [11:0] pix_in_r = '0, pix_in_g = '0, pix_in_b = '0;
   logic        pix_out_valid;
   logic [11:0] pix_out_r, pix_out_g, pix_out_b;

   int n_chk = 0;
   int n_err = 0;
   int sh [9];
   int ac [9];
   bit armed_m = 1'b0;

   always #2 clk = ~clk;

   rgb_matrix_xform u0 (
      .clk(clk), .rst_n(rst_n), .coef_wr(coef_wr), .coef_idx(coef_idx),
      .coef_data(coef_data), .coef_commit(coef_commit),
      .frame_start(frame_start), .coef_err(coef_err),
      .pix_in_valid(pix_in_valid), .pix_in_r(pix_in_r), .pix_in_g(pix_in_g),
      .pix_in_b(pix_in_b), .pix_out_valid(pix_out_valid),
      .pix_out_r(pix_out_r), .pix_out_g(pix_out_g), .pix_out_b(pix_out_b)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // model of the conversion (R4, R5)
   task automatic conv_model(input bit s, input int m, output int val, output bit bad);
      int c;
      c = s ? ((~m + 1) & 32'h7FFF) : m;
      bad = (s != c[14]);
      val = (c >= 16384) ? c - 32768 : c;
   endtask

   task automatic wr_coef(input int idx, input bit s, input int m, input int salt);
      int val;
      bit bad;
      bit exp_err;
      conv_model(s, m, val, bad);
      coef_wr   = 1'b1;
      coef_idx  = idx[3:0];
      coef_data = {s, 28'(salt * 32'h9E3779B1), m[14:0], 20'(salt * 7919)};
      @(negedge clk);
      coef_wr = 1'b0;
      exp_err = (idx < 9) && bad;
      check(idx < 9 ? "R5/R6 coef_err" : "R7 coef_err", coef_err, exp_err);
      if (idx < 9 && !bad) sh[idx] = val;
   endtask

   task automatic do_frame(input bit with_commit);
      frame_start = 1'b1;
      coef_commit = with_commit;
      @(negedge clk);
      frame_start = 1'b0;
      coef_commit = 1'b0;
      if (armed_m || with_commit) for (int k = 0; k < 9; k++) ac[k] = sh[k];
      armed_m = 1'b0;
   endtask

   task automatic do_commit();
      coef_commit = 1'b1;
      @(negedge clk);
      coef_commit = 1'b0;
      armed_m = 1'b1;
   endtask

   function automatic int exp_comp(input int row, input int r, input int g, input int b);
      longint s;
      longint v;
      s = longint'(ac[row*3]) * r + longint'(ac[row*3+1]) * g + longint'(ac[row*3+2]) * b;
      v = (s + 2048) >>> 12;
      if (v < 0) v = 0;
      if (v > 4095) v = 4095;
      return int'(v);
   endfunction

   task automatic run_pix(input string tag, input int r, input int g, input int b);
      pix_in_valid = 1'b1;
      pix_in_r = r[11:0];
      pix_in_g = g[11:0];
      pix_in_b = b[11:0];
      @(negedge clk);
      pix_in_valid = 1'b0;
      check({tag, " R3 valid early"}, pix_out_valid, 0);
      @(negedge clk);
      check({tag, " R3 valid"}, pix_out_valid, 1);
      check({tag, " R2 red"}, pix_out_r, exp_comp(0, r, g, b));
      check({tag, " R2 green"}, pix_out_g, exp_comp(1, r, g, b));
      check({tag, " R2 blue"}, pix_out_b, exp_comp(2, r, g, b));
      @(negedge clk);
      check({tag, " R3 single valid"}, pix_out_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int k = 0; k < 9; k++) begin
         sh[k] = (k % 4 == 0) ? 4096 : 0;
         ac[k] = sh[k];
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid in reset", pix_out_valid, 0);
      check("R1 err in reset", coef_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", pix_out_valid, 0);
      check("R1 err after reset", coef_err, 0);
      run_pix("R1 identity a", 100, 2000, 4095);
      run_pix("R1 identity b", 0, 0, 0);

      // R4 R5 R6: full magnitude sweep on index 0 with scrambled ignored bits
      for (int s = 0; s < 2; s++)
         for (int m = 0; m < 32768; m++)
            wr_coef(0, s[0], m, m + s * 40000);
      // R8: nothing committed yet
      run_pix("R8 no commit", 1234, 567, 89);
      do_commit();
      run_pix("R9 armed not applied", 1234, 567, 89);
      do_frame(1'b0);
      run_pix("R9 applied at frame", 1234, 567, 89);

      // R4: converted values reach the multiplier (offset via green weight)
      wr_coef(1, 1'b0, 32'h1000, 3);
      wr_coef(2, 1'b0, 0, 4);
      for (int s = 0; s < 2; s++)
         for (int m = 0; m < 32768; m += 61) begin
            int val;
            bit bad;
            conv_model(s[0], m, val, bad);
            wr_coef(0, s[0], m, m * 3 + 11);
            if (!bad) begin
               do_frame(1'b1);
               run_pix("R4 value", 1000, 2048, 0);
            end
         end
      // R5 corner: -4.0 accepted, -0 rejected
      wr_coef(0, 1'b1, 32'h4000, 77);
      wr_coef(0, 1'b1, 0, 78);
      do_frame(1'b1);
      run_pix("R5 minus four", 7, 2048, 0);

      // R6: rejected write keeps earlier accepted value
      wr_coef(0, 1'b0, 32'h0800, 5);
      wr_coef(0, 1'b0, 32'h4000, 6);
      do_frame(1'b1);
      run_pix("R6 shadow kept", 1000, 2048, 0);
      run_pix("R6 rounding tie", 1, 2048, 0);

      // R7: out-of-range indices
      wr_coef(9, 1'b0, 32'h4000, 8);
      wr_coef(15, 1'b0, 32'h0100, 9);
      wr_coef(12, 1'b1, 0, 10);
      do_frame(1'b1);
      run_pix("R7 no effect", 1000, 2048, 0);

      // R2: mixed-sign full matrix
      wr_coef(0, 1'b0, 32'h2000, 20);
      wr_coef(1, 1'b1, 32'h1000, 21);
      wr_coef(2, 1'b0, 32'h0800, 22);
      wr_coef(3, 1'b1, 32'h3800, 23);
      wr_coef(4, 1'b0, 0, 24);
      wr_coef(5, 1'b0, 0, 25);
      wr_coef(6, 1'b0, 32'h3FFF, 26);
      wr_coef(7, 1'b0, 32'h1000, 27);
      wr_coef(8, 1'b0, 32'h1000, 28);
      // R8: shadow changed, active still old
      run_pix("R8 before frame", 1000, 3000, 17);
      do_frame(1'b1);
      run_pix("R2 full", 4095, 4095, 4095);
      run_pix("R2 green only", 0, 4095, 0);
      run_pix("R2 mid", 1000, 3000, 17);
      run_pix("R2 red only", 4095, 0, 0);
      run_pix("R2 small", 3, 1, 2);

      // R9: frame_start consumes the arm
      do_commit();
      do_frame(1'b0);
      wr_coef(0, 1'b0, 32'h1000, 30);
      wr_coef(4, 1'b0, 32'h1000, 31);
      do_frame(1'b0);
      run_pix("R9 arm consumed", 1000, 3000, 17);
      do_frame(1'b1);
      run_pix("R9 same-cycle commit", 1000, 3000, 17);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule